// File: doc/BRIEF.md
# Level/Edge Interrupt Redirection Controller

This block sits between a set of interrupt input pins and the message fabric of a processor complex. Each pin owns one redirection entry. An entry holds a vector, a trigger mode, a mask and a remote-pending flag that software can read but not write. An edge entry sends one delivery message, carrying its vector, for each rising edge of its pin. A level entry sends a message while its pin is high and then sets its remote-pending flag. The flag holds off any further message from that pin until an end-of-interrupt clears it.

The flag has three ways to clear. The first is an end-of-interrupt broadcast whose vector matches the entry. The second is a write to a directed end-of-interrupt register, which exists only when the version parameter is 0x20 or higher. The third is switching the entry to edge mode and back to level. Software reaches every register through an index register and a 32-bit data window. Each pin raises its own delivery strobe, so there is no arbitration between pins.

Top module: `intr_redir_unit`

## Requirements
- R1: After reset every entry reads 0x0001_0000 (masked, edge mode, vector 0, flag clear) and no delivery strobe is active.
- R2: A level entry that is unmasked, has its flag clear and sees its pin high raises `deliverValid` on the next clock with `deliverVec` equal to the entry vector, and its flag reads set from that clock on.
- R3: While a level entry's flag is set, its pin sends no message even if the pin stays high.
- R4: An end-of-interrupt broadcast clears the flag of a level entry whose vector equals `eoiBcVec`. If the pin is still high, the pin delivers again.
- R5: A broadcast whose vector differs from the entry's current vector leaves the flag set. This includes the old vector of an entry that was reprogrammed while pending.
- R6: A data write while the index is 0x40 (the end-of-interrupt register, vector in bits 7:0) clears the flag of every level entry whose vector matches, when `Version` is at least 0x20.
- R7: With `Version` below 0x20, a write at index 0x40 has no effect on any flag.
- R8: A write that puts an entry in edge mode (bit 15 = 0) clears its flag. Returning the entry to level mode gives an entry that delivers again when its pin is high.
- R9: A masked entry (bit 16 = 1) sends no message, and the mask leaves its flag unchanged.
- R10: An edge entry (bit 15 = 0) delivers once per rising edge of its pin and never sets its flag.
- R11: A read at index 0x01 returns `Version` in bits 7:0 and zero in every other bit.
- R12: Entry n has its low word at index 0x10+2n: vector in bits 7:0, flag in bit 14 (writes to this bit are ignored), trigger mode in bit 15 (1 = level), mask in bit 16. The high word at 0x11+2n reads zero.
- R13: When a clear and a still-high level line meet in the same cycle, the clear takes effect first and the message goes out on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NumPins | Interrupt input pins |
| idxWe | input | 1 | Load the index register from wdata[7:0] |
| dataWe | input | 1 | Write wdata into the window selected by the index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Contents of the window selected by the index |
| eoiBcValid | input | 1 | End-of-interrupt broadcast strobe |
| eoiBcVec | input | 8 | Vector carried by the broadcast |
| deliverValid | output | NumPins | Per-pin delivery message strobe |
| deliverVec | output | 8*NumPins | Per-pin vector of the message, pin n in bits 8n+7:8n |

## Verification
The checker assumes that pins, strobes and broadcast inputs change only between clock edges. It also assumes that no source other than the data write path and the broadcast input can clear a flag. The bench drives every input at the falling edge and keeps `idxWe` and `dataWe` mutually exclusive. Random traffic uses only four vectors, so that broadcasts and end-of-interrupt register writes often hit entries, and often hit entries that were reprogrammed while pending. A second instance built with version 0x11 gets the same stimulus, so the ignored register write is seen directly in its read-back flag.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;
  localparam int VecW = 8;
  localparam int WinW = 32;
  localparam int IdxW = 8;
  localparam int SelW = 6;

  // field positions inside an entry low word
  localparam int RpBit   = 14;
  localparam int TrigBit = 15;
  localparam int MaskBit = 16;

  localparam logic [IdxW-1:0] IdxVer     = 8'h01;
  localparam logic [IdxW-1:0] IdxEntBase = 8'h10;
  localparam logic [IdxW-1:0] IdxEoi     = 8'h40;
  localparam logic [7:0]      VerEoiMin  = 8'h20;

  typedef struct packed {
    logic            entWr;
    logic [SelW-1:0] entSel;
    logic            eoiWr;
  } ctrlStrobes_t;
endpackage

// File: rtl/intr_route_ctrl.sv
module intr_route_ctrl
  import intr_route_pkg::*;
#(
  parameter int         NumPins = 4,
  parameter logic [7:0] Version = 8'h20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    idxWe,
  input  logic                    dataWe,
  input  logic [WinW-1:0]         wdata,
  input  logic [NumPins*VecW-1:0] entVec,
  input  logic [NumPins-1:0]      entTrig,
  input  logic [NumPins-1:0]      entMask,
  input  logic [NumPins-1:0]      entRp,
  output ctrlStrobes_t            strobes,
  output logic [WinW-1:0]         rdata
);
  localparam logic [IdxW-1:0] EntEnd = IdxEntBase + IdxW'(2 * NumPins);

  logic [IdxW-1:0] idxReg;
  logic [IdxW-1:0] winOff;
  logic            isEnt;
  logic            isLow;
  logic [SelW-1:0] entSel;

  always_ff @(posedge clk) begin
    if (!rstN) idxReg <= '0;
    else if (idxWe) idxReg <= wdata[IdxW-1:0];
  end

  assign winOff = idxReg - IdxEntBase;
  assign isEnt  = (idxReg >= IdxEntBase) && (idxReg < EntEnd);
  assign isLow  = ~winOff[0];
  assign entSel = winOff[SelW:1];

  assign strobes.entWr  = dataWe && isEnt && isLow;
  assign strobes.entSel = entSel;

  generate
    if (Version >= VerEoiMin) begin : g_eoiReg
      assign strobes.eoiWr = dataWe && (idxReg == IdxEoi);
    end else begin : g_noEoiReg
      assign strobes.eoiWr = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (idxReg == IdxVer) begin
      rdata[7:0] = Version;
    end else if (isEnt && isLow) begin
      for (int p = 0; p < NumPins; p++) begin
        if (entSel == SelW'(p)) begin
          rdata[VecW-1:0] = entVec[p*VecW +: VecW];
          rdata[RpBit]    = entRp[p];
          rdata[TrigBit]  = entTrig[p];
          rdata[MaskBit]  = entMask[p];
        end
      end
    end
  end
endmodule

// File: rtl/intr_route_entries.sv
module intr_route_entries
  import intr_route_pkg::*;
#(
  parameter int NumPins = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NumPins-1:0]      pinIn,
  input  ctrlStrobes_t            strobes,
  input  logic [WinW-1:0]         wdata,
  input  logic                    eoiBcValid,
  input  logic [VecW-1:0]         eoiBcVec,
  output logic [NumPins*VecW-1:0] entVec,
  output logic [NumPins-1:0]      entTrig,
  output logic [NumPins-1:0]      entMask,
  output logic [NumPins-1:0]      entRp,
  output logic [NumPins-1:0]      deliverValid,
  output logic [NumPins*VecW-1:0] deliverVec
);
  generate
    for (genvar i = 0; i < NumPins; i++) begin : g_ent
      logic [VecW-1:0] vecQ;
      logic [VecW-1:0] dvecQ;
      logic            trigQ, maskQ, rpQ, prevQ, dvQ;
      logic            wrMe, fire, modeClr, eoiHit;

      assign wrMe    = strobes.entWr && (strobes.entSel == SelW'(i));
      assign fire    = trigQ ? (pinIn[i] && !maskQ && !rpQ)
                             : (pinIn[i] && !prevQ && !maskQ);
      assign modeClr = wrMe && !wdata[TrigBit];
      assign eoiHit  = (eoiBcValid && (eoiBcVec == vecQ)) ||
                       (strobes.eoiWr && (wdata[VecW-1:0] == vecQ));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          vecQ  <= '0;
          trigQ <= 1'b0;
          maskQ <= 1'b1;
          rpQ   <= 1'b0;
          prevQ <= 1'b0;
          dvQ   <= 1'b0;
          dvecQ <= '0;
        end else begin
          prevQ <= pinIn[i];
          dvQ   <= fire;
          if (fire) dvecQ <= vecQ;
          if (modeClr)            rpQ <= 1'b0;
          else if (fire && trigQ) rpQ <= 1'b1;
          else if (eoiHit)        rpQ <= 1'b0;
          if (wrMe) begin
            vecQ  <= wdata[VecW-1:0];
            trigQ <= wdata[TrigBit];
            maskQ <= wdata[MaskBit];
          end
        end
      end

      assign entVec[i*VecW +: VecW]     = vecQ;
      assign entTrig[i]                 = trigQ;
      assign entMask[i]                 = maskQ;
      assign entRp[i]                   = rpQ;
      assign deliverValid[i]            = dvQ;
      assign deliverVec[i*VecW +: VecW] = dvecQ;
    end
  endgenerate
endmodule

// File: rtl/intr_redir_unit.sv
module intr_redir_unit
  import intr_route_pkg::*;
#(
  parameter int         NumPins = 4,
  parameter logic [7:0] Version = 8'h20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NumPins-1:0]      pinIn,
  input  logic                    idxWe,
  input  logic                    dataWe,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic                    eoiBcValid,
  input  logic [7:0]              eoiBcVec,
  output logic [NumPins-1:0]      deliverValid,
  output logic [NumPins*8-1:0]    deliverVec
);
  ctrlStrobes_t              strobes;
  logic [NumPins*VecW-1:0]   entVec;
  logic [NumPins-1:0]        entTrig;
  logic [NumPins-1:0]        entMask;
  logic [NumPins-1:0]        entRp;

  intr_route_ctrl #(.NumPins(NumPins), .Version(Version)) uCtrl (
    .clk(clk), .rstN(rstN), .idxWe(idxWe), .dataWe(dataWe), .wdata(wdata),
    .entVec(entVec), .entTrig(entTrig), .entMask(entMask), .entRp(entRp),
    .strobes(strobes), .rdata(rdata)
  );

  intr_route_entries #(.NumPins(NumPins)) uEnt (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strobes(strobes), .wdata(wdata),
    .eoiBcValid(eoiBcValid), .eoiBcVec(eoiBcVec),
    .entVec(entVec), .entTrig(entTrig), .entMask(entMask), .entRp(entRp),
    .deliverValid(deliverValid), .deliverVec(deliverVec)
  );
endmodule

// File: rtl/intr_redir_chk.sv
module intr_redir_chk #(
  parameter int NumPins = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NumPins-1:0] entRp,
  input logic [NumPins-1:0] entTrig,
  input logic [NumPins-1:0] entMask,
  input logic [NumPins-1:0] deliverValid,
  input logic               eoiBcValid,
  input logic               dataWe
);
  generate
    for (genvar i = 0; i < NumPins; i++) begin : g_chk
      // R3
      pending_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
        entRp[i] |=> !deliverValid[i]);
      // R2
      pending_from_delivery_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(entRp[i]) |-> deliverValid[i]);
      // R4
      clear_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
        $fell(entRp[i]) |-> ($past(eoiBcValid) || $past(dataWe)));
      // R9
      masked_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
        entMask[i] |=> !deliverValid[i]);
      // R10
      edge_no_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
        !entTrig[i] |=> !entRp[i]);
    end
  endgenerate
endmodule

bind intr_redir_unit intr_redir_chk #(.NumPins(NumPins)) uChk (
  .clk(clk), .rstN(rstN), .entRp(entRp), .entTrig(entTrig), .entMask(entMask),
  .deliverValid(deliverValid), .eoiBcValid(eoiBcValid), .dataWe(dataWe)
);

// File: tb/sim_intr_redir_unit.sv
module sim_intr_redir_unit;
  localparam int ClkPeriod = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic idxWe = 1'b0, dataWe = 1'b0;
  logic [31:0] wdata = '0;
  logic bcV = 1'b0;
  logic [7:0] bcVec = '0;
  logic [31:0] rdata0, rdata1;
  logic [NP-1:0] dv0, dv1;
  logic [NP*8-1:0] dvec0, dvec1;

  int checks = 0, fails = 0;
  bit finished = 0;
  string tag = "R1";

  always #(ClkPeriod/2) clk = ~clk;

  intr_redir_unit #(.NumPins(NP), .Version(8'h20)) u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .idxWe(idxWe), .dataWe(dataWe),
    .wdata(wdata), .rdata(rdata0), .eoiBcValid(bcV), .eoiBcVec(bcVec),
    .deliverValid(dv0), .deliverVec(dvec0));
  intr_redir_unit #(.NumPins(NP), .Version(8'h11)) u1 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .idxWe(idxWe), .dataWe(dataWe),
    .wdata(wdata), .rdata(rdata1), .eoiBcValid(bcV), .eoiBcVec(bcVec),
    .deliverValid(dv1), .deliverVec(dvec1));

  // reference state, instance 0 has the EOI register, instance 1 not
  logic [7:0] mVec [2][NP];
  bit mTrig [2][NP], mMask [2][NP], mRp [2][NP];
  bit mPrev [NP];
  logic [7:0] mIdx;
  bit eDv [2][NP];
  logic [7:0] eVec [2][NP];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRd(input int k);
    logic [31:0] r = '0;
    if (mIdx == 8'h01) r[7:0] = (k == 0) ? 8'h20 : 8'h11;
    else if (mIdx >= 8'h10 && mIdx < 8'h10 + 8'(2*NP) && !mIdx[0]) begin
      int i = int'(mIdx - 8'h10) >> 1;
      r[7:0] = mVec[k][i];
      r[14] = mRp[k][i];
      r[15] = mTrig[k][i];
      r[16] = mMask[k][i];
    end
    return r;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < NP; i++) begin
        mVec[k][i] = '0; mTrig[k][i] = 0; mMask[k][i] = 1; mRp[k][i] = 0;
        eDv[k][i] = 0; eVec[k][i] = '0;
      end
    for (int i = 0; i < NP; i++) mPrev[i] = 0;
    mIdx = '0;
  endtask

  task automatic modelStep();
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < NP; i++) begin
        bit fire, wr, eoi, nRp;
        fire = mTrig[k][i] ? (pinIn[i] && !mMask[k][i] && !mRp[k][i])
                           : (pinIn[i] && !mPrev[i] && !mMask[k][i]);
        eDv[k][i] = fire;
        if (fire) eVec[k][i] = mVec[k][i];
        wr  = dataWe && (mIdx == 8'(16 + 2*i));
        eoi = (bcV && bcVec == mVec[k][i]) ||
              (k == 0 && dataWe && mIdx == 8'h40 && wdata[7:0] == mVec[k][i]);
        if (wr && !wdata[15]) nRp = 0;
        else if (fire && mTrig[k][i]) nRp = 1;
        else if (eoi) nRp = 0;
        else nRp = mRp[k][i];
        mRp[k][i] = nRp;
        if (wr) begin
          mVec[k][i] = wdata[7:0]; mTrig[k][i] = wdata[15]; mMask[k][i] = wdata[16];
        end
      end
    for (int i = 0; i < NP; i++) mPrev[i] = pinIn[i];
    if (idxWe) mIdx = wdata[7:0];
  endtask

  task automatic compareAll();
    for (int i = 0; i < NP; i++) begin
      chk(dv0[i] == eDv[0][i] && (!eDv[0][i] || dvec0[i*8 +: 8] == eVec[0][i]),
          tag, {dv0[i], dvec0[i*8 +: 8]}, {eDv[0][i], eVec[0][i]});
      chk(dv1[i] == eDv[1][i] && (!eDv[1][i] || dvec1[i*8 +: 8] == eVec[1][i]),
          tag, {dv1[i], dvec1[i*8 +: 8]}, {eDv[1][i], eVec[1][i]});
    end
    chk(rdata0 == expRd(0), tag, rdata0, expRd(0));
    chk(rdata1 == expRd(1), tag, rdata1, expRd(1));
  endtask

  task automatic step();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [31:0] d);
    idxWe = 1; wdata = {24'h0, idx}; step(); idxWe = 0;
    dataWe = 1; wdata = d; step(); dataWe = 0;
  endtask

  task automatic readChk(input logic [7:0] idx, input logic [31:0] e0, input string t0,
                         input logic [31:0] e1, input string t1);
    idxWe = 1; wdata = {24'h0, idx}; step(); idxWe = 0;
    chk(rdata0 == e0, t0, rdata0, e0);
    chk(rdata1 == e1, t1, rdata1, e1);
  endtask

  task automatic dvChk(input int p, input bit e, input string t);
    chk(dv0[p] == e, t, 32'(dv0[p]), 32'(e));
    chk(dv1[p] == e, t, 32'(dv1[p]), 32'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20091102));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    tag = "R1";
    step();
    for (int i = 0; i < NP; i++) dvChk(i, 0, "R1");
    readChk(8'h10, 32'h0001_0000, "R1", 32'h0001_0000, "R1");
    readChk(8'h16, 32'h0001_0000, "R1", 32'h0001_0000, "R1");
    // R11 version window
    tag = "R11";
    readChk(8'h01, 32'h20, "R11", 32'h11, "R11");
    // R2 level delivery
    tag = "R2";
    wrReg(8'h10, 32'h0000_8041);
    pinIn[0] = 1; step();
    dvChk(0, 1, "R2");
    chk(dvec0[7:0] == 8'h41, "R2", 32'(dvec0[7:0]), 32'h41);
    // R3 pending blocks while line stays high
    tag = "R3";
    for (int c = 0; c < 4; c++) begin step(); dvChk(0, 0, "R3"); end
    readChk(8'h10, 32'h0000_C041, "R3", 32'h0000_C041, "R3");
    // R4 / R13 broadcast clear and redelivery ordering
    tag = "R13";
    bcV = 1; bcVec = 8'h41; step(); bcV = 0;
    dvChk(0, 0, "R13");
    step(); dvChk(0, 1, "R4");
    // R5 stuck after reprogramming
    tag = "R5";
    pinIn[0] = 0;
    wrReg(8'h10, 32'h0000_8042);
    bcV = 1; bcVec = 8'h41; step(); bcV = 0;
    readChk(8'h10, 32'h0000_C042, "R5", 32'h0000_C042, "R5");
    // R6 / R7 directed EOI register
    tag = "R6";
    wrReg(8'h40, 32'h0000_0042);
    readChk(8'h10, 32'h0000_8042, "R6", 32'h0000_C042, "R7");
    // R8 edge/level toggle recovery
    tag = "R8";
    wrReg(8'h10, 32'h0001_0042);
    wrReg(8'h10, 32'h0001_8042);
    wrReg(8'h10, 32'h0000_8042);
    readChk(8'h10, 32'h0000_8042, "R8", 32'h0000_8042, "R8");
    pinIn[0] = 1; step(); dvChk(0, 1, "R8");
    // R9 mask
    tag = "R9";
    wrReg(8'h10, 32'h0001_8042);
    bcV = 1; bcVec = 8'h42; step(); bcV = 0;
    for (int c = 0; c < 3; c++) begin step(); dvChk(0, 0, "R9"); end
    readChk(8'h10, 32'h0001_8042, "R9", 32'h0001_8042, "R9");
    wrReg(8'h10, 32'h0000_8042);
    step(); dvChk(0, 1, "R9");
    // R10 edge entry
    tag = "R10";
    wrReg(8'h12, 32'h0000_0050);
    pinIn[1] = 1; step(); dvChk(1, 1, "R10");
    for (int c = 0; c < 3; c++) begin step(); dvChk(1, 0, "R10"); end
    pinIn[1] = 0; step(); dvChk(1, 0, "R10");
    pinIn[1] = 1; step(); dvChk(1, 1, "R10");
    readChk(8'h12, 32'h0000_0050, "R10", 32'h0000_0050, "R10");
    // R12 layout, read-only flag, high window
    tag = "R12";
    wrReg(8'h14, 32'h0000_4060);
    readChk(8'h14, 32'h0000_0060, "R12", 32'h0000_0060, "R12");
    readChk(8'h11, 32'h0, "R12", 32'h0, "R12");
    // random traffic, mostly R2..R6 interplay
    tag = "R2";
    for (int c = 0; c < 4000; c++) begin
      int r = int'($urandom_range(0, 99));
      for (int i = 0; i < NP; i++)
        if ($urandom_range(0, 99) < 15) pinIn[i] = ~pinIn[i];
      idxWe = 0; dataWe = 0; bcV = 0;
      if (r < 10) begin
        int s = int'($urandom_range(0, 9));
        idxWe = 1;
        wdata = {24'h0, (s < 8) ? 8'(16 + s) : (s == 8 ? 8'h40 : 8'h01)};
      end else if (r < 25) begin
        dataWe = 1;
        wdata = '0;
        wdata[7:0] = 8'h30 + 8'($urandom_range(0, 3));
        wdata[14] = 1'($urandom_range(0, 1));
        wdata[15] = ($urandom_range(0, 3) != 0);
        wdata[16] = ($urandom_range(0, 4) == 0);
      end
      if ($urandom_range(0, 9) == 0) begin
        bcV = 1; bcVec = 8'h30 + 8'($urandom_range(0, 3));
      end
      step();
    end
    idxWe = 0; dataWe = 0; bcV = 0;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule